// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block owns the chip-wide reset. It holds `chip_rst_o` high from power-on until master clear has been released and a fixed power-up delay has run out. The delay is measured in pulses of an on-chip slow clock, and the analog trip detector, the slow RC oscillator and the sleep controller all sit outside the block. When the main oscillator is a crystal or resonator, which the block sees through `osc_xtal_i`, a second counter also has to see a set number of main-oscillator edges. Reset is released only when both counters have finished, so the longer of the two delays sets the hold time.

After power-up the block handles the other ways a reset or wake-up can happen. A master clear holds reset for as long as it is low. A watchdog expiry during normal operation gives a single-cycle reset. A watchdog expiry or an interrupt during sleep gives no reset at all: it returns to normal operation through `wake_done_o`, after the oscillator start-up count when the oscillator is a crystal. A cycle of `chip_rst_o` sends the program counter to the reset vector 0000h. A `wake_done_o` pulse means execution carries on at the next address.

Two status bits, `to_o` and `pd_o`, tell software the cause of the most recent reset or wake-up. Every input here is a plain control pin sampled on `clk_i`, the tick inputs are one-cycle pulses, and there is no streaming interface.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_ok_i` is low, the block is held in its power-on state at once, without waiting for a clock edge: `chip_rst_o`=1, `to_o`=1, `pd_o`=1 and `wake_done_o`=0.
- R2: On power-up with `osc_xtal_i`=0, `chip_rst_o` stays high until PWRT_TICKS slow ticks have been sampled while master clear is high. It falls at the second clock edge after the last of those ticks, and `osc_tick_i` has no effect on it.
- R3: On power-up with `osc_xtal_i`=1, `chip_rst_o` also waits for OST_CYCLES oscillator ticks. It falls at the second edge after whichever count completes later.
- R4: Power-up counting starts only once `mclr_ni` is high. Ticks that arrive while `mclr_ni` is low are ignored, and a low pulse on `mclr_ni` in the middle of the sequence restarts both counts from zero.
- R5: After power-up, `mclr_ni` low sets `chip_rst_o` at the next edge and holds it for as long as `mclr_ni` stays low. Once `mclr_ni` is high again, `chip_rst_o` clears at the next edge with no delay. The status pair (`to_o`,`pd_o`) becomes 11 if `sleeping_i` was low when master clear arrived, and 10 if it was high.
- R6: A `wdt_timeout_i` pulse while awake gives exactly one cycle of `chip_rst_o`, starting at the next edge, and sets the status pair to 01.
- R7: A `wdt_timeout_i` pulse while `sleeping_i`=1 gives no reset. It sets the status pair to 00 and produces a one-cycle `wake_done_o`.
- R8: A `wake_evt_i` pulse while `sleeping_i`=1 sets the status pair to 10 and gives no reset. With `osc_xtal_i`=0, `wake_done_o` is high for one cycle, two edges after the pulse is sampled.
- R9: With `osc_xtal_i`=1, the `wake_done_o` pulse of a wake-up waits for OST_CYCLES oscillator ticks counted from the wake event. It comes at the second edge after the last of those ticks.
- R10: A `clrwdt_i` pulse while awake sets the status pair to 11 at the next edge.
- R11: A `wake_evt_i` pulse while `sleeping_i`=0 has no effect: no `wake_done_o`, no reset, and the status pair is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_ok_i | input | 1 | Supply above trip point; low acts as asynchronous power-on reset |
| mclr_ni | input | 1 | Master clear, active low |
| osc_xtal_i | input | 1 | 1 when the main oscillator is a crystal or resonator |
| slow_tick_i | input | 1 | One-cycle pulse per period of the on-chip slow clock |
| osc_tick_i | input | 1 | One-cycle pulse per main-oscillator edge |
| wdt_timeout_i | input | 1 | One-cycle watchdog expiry pulse |
| sleeping_i | input | 1 | Device is in the power-down state |
| wake_evt_i | input | 1 | One-cycle interrupt wake-up request |
| clrwdt_i | input | 1 | One-cycle clear-watchdog instruction strobe |
| chip_rst_o | output | 1 | Internal chip reset; program counter goes to 0000h |
| wake_done_o | output | 1 | One-cycle pulse: leave sleep, resume at the next address |
| to_o | output | 1 | Status bit: 0 after a watchdog expiry |
| pd_o | output | 1 | Status bit: 0 after an event that occurred in sleep |

## Verification
Status bits and the set of `chip_rst_o` are due one edge after the input that causes them is sampled. A release after a delay, and a `wake_done_o` pulse, are due two edges after the last counted tick, because the counter's done flag and the state register each add one edge. Every stimulus goes onto a queue together with the expected output values and the cycle in which they are due. The monitor compares each entry only in that cycle, a quarter period after the edge, so an output that comes one cycle early or one cycle late is reported. The bench also checks the cycle just before each expected release, so that a count that finishes too early is caught as well.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    SQ_PWRUP,
    SQ_MCLR,
    SQ_RUN,
    SQ_WDTRST,
    SQ_WAKE
  } seq_state_e;

  typedef enum logic [2:0] {
    ST_NONE,
    ST_CLEAN,
    ST_SLEEP,
    ST_WDT_RUN,
    ST_WDT_SLEEP
  } stat_evt_e;
endpackage

// File: rtl/rstseq_delay_cnt.sv
module rstseq_delay_cnt #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  // R2/R3: the count never passes its limit
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R3: completion only follows a sampled tick
  a_r3_done_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(tick_i));
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
  import rstseq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  stat_evt_e evt_i,
  output logic      to_o,
  output logic      pd_o
);
  logic to_q, pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else begin
      unique case (evt_i)
        ST_CLEAN:     begin to_q <= 1'b1; pd_q <= 1'b1; end
        ST_SLEEP:     begin to_q <= 1'b1; pd_q <= 1'b0; end
        ST_WDT_RUN:   begin to_q <= 1'b0; pd_q <= 1'b1; end
        ST_WDT_SLEEP: begin to_q <= 1'b0; pd_q <= 1'b0; end
        default:      ;
      endcase
    end
  end

  assign to_o = to_q;
  assign pd_o = pd_q;

  // R11: without an event the status pair holds
  a_r11_status_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == ST_NONE) |=> ($stable(to_q) && $stable(pd_q)));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned PWRT_TICKS = 1024,
  parameter int unsigned OST_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic por_ok_i,
  input  logic mclr_ni,
  input  logic osc_xtal_i,
  input  logic slow_tick_i,
  input  logic osc_tick_i,
  input  logic wdt_timeout_i,
  input  logic sleeping_i,
  input  logic wake_evt_i,
  input  logic clrwdt_i,
  output logic chip_rst_o,
  output logic wake_done_o,
  output logic to_o,
  output logic pd_o
);
  seq_state_e state_q, state_d;
  stat_evt_e  evt;
  logic       chip_rst_q, wake_done_q;
  logic       pwrt_done, ost_done;
  logic       pwrt_clr, ost_clr, ost_tick;

  assign pwrt_clr = (state_q != SQ_PWRUP) || !mclr_ni;
  assign ost_clr  = !(((state_q == SQ_PWRUP) && mclr_ni) || (state_q == SQ_WAKE));
  assign ost_tick = osc_tick_i && osc_xtal_i;

  rstseq_delay_cnt #(.LIMIT(PWRT_TICKS)) u_pwrt (
    .clk_i  (clk_i),
    .rst_ni (por_ok_i),
    .clr_i  (pwrt_clr),
    .tick_i (slow_tick_i),
    .done_o (pwrt_done)
  );

  rstseq_delay_cnt #(.LIMIT(OST_CYCLES)) u_ost (
    .clk_i  (clk_i),
    .rst_ni (por_ok_i),
    .clr_i  (ost_clr),
    .tick_i (ost_tick),
    .done_o (ost_done)
  );

  always_comb begin
    state_d = state_q;
    evt     = ST_NONE;
    unique case (state_q)
      SQ_PWRUP: begin
        if (mclr_ni && pwrt_done && (ost_done || !osc_xtal_i)) state_d = SQ_RUN;
      end
      SQ_MCLR: begin
        if (mclr_ni) state_d = SQ_RUN;
      end
      SQ_RUN: begin
        if (!mclr_ni) begin
          state_d = SQ_MCLR;
          evt     = sleeping_i ? ST_SLEEP : ST_CLEAN;
        end else if (wdt_timeout_i) begin
          state_d = sleeping_i ? SQ_WAKE : SQ_WDTRST;
          evt     = sleeping_i ? ST_WDT_SLEEP : ST_WDT_RUN;
        end else if (wake_evt_i && sleeping_i) begin
          state_d = SQ_WAKE;
          evt     = ST_SLEEP;
        end else if (clrwdt_i) begin
          evt     = ST_CLEAN;
        end
      end
      SQ_WDTRST: begin
        if (!mclr_ni) begin
          state_d = SQ_MCLR;
          evt     = ST_CLEAN;
        end else begin
          state_d = SQ_RUN;
        end
      end
      SQ_WAKE: begin
        if (!mclr_ni) begin
          state_d = SQ_MCLR;
          evt     = ST_SLEEP;
        end else if (!osc_xtal_i || ost_done) begin
          state_d = SQ_RUN;
        end
      end
      default: state_d = SQ_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge por_ok_i) begin
    if (!por_ok_i) begin
      state_q     <= SQ_PWRUP;
      chip_rst_q  <= 1'b1;
      wake_done_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      chip_rst_q  <= (state_d == SQ_PWRUP) || (state_d == SQ_MCLR) ||
                     (state_d == SQ_WDTRST);
      wake_done_q <= (state_q == SQ_WAKE) && (state_d == SQ_RUN);
    end
  end

  rstseq_status u_status (
    .clk_i  (clk_i),
    .rst_ni (por_ok_i),
    .evt_i  (evt),
    .to_o   (to_o),
    .pd_o   (pd_o)
  );

  assign chip_rst_o  = chip_rst_q;
  assign wake_done_o = wake_done_q;

  // R5: master clear low always yields reset at the next edge
  a_r5_mclr_forces_rst: assert property (@(posedge clk_i) disable iff (!por_ok_i)
    !mclr_ni |=> chip_rst_o);
  // R6: watchdog reset in normal operation lasts one cycle
  a_r6_wdt_single_cycle: assert property (@(posedge clk_i) disable iff (!por_ok_i)
    (state_q == SQ_WDTRST && mclr_ni) |=> !chip_rst_o);
  // R6: awake watchdog expiry gives reset and status 01
  a_r6_wdt_status: assert property (@(posedge clk_i) disable iff (!por_ok_i)
    (state_q == SQ_RUN && mclr_ni && wdt_timeout_i && !sleeping_i) |=>
    (chip_rst_o && !to_o && pd_o));
  // R7: no reset while leaving sleep
  a_r7_no_rst_in_wake: assert property (@(posedge clk_i) disable iff (!por_ok_i)
    (state_q == SQ_WAKE) |-> !chip_rst_o);
  // R9: crystal wake-up waits for the start-up count
  a_r9_wake_after_ost: assert property (@(posedge clk_i) disable iff (!por_ok_i)
    (wake_done_o && $past(osc_xtal_i)) |-> $past(ost_done));
  // R3: power-up release only after the power-up delay
  a_r3_release_after_pwrt: assert property (@(posedge clk_i) disable iff (!por_ok_i)
    ($fell(chip_rst_o) && $past(state_q == SQ_PWRUP)) |-> $past(pwrt_done));
  // R8: a wake pulse never coincides with reset
  a_r8_wake_not_rst: assert property (@(posedge clk_i) disable iff (!por_ok_i)
    !(wake_done_o && chip_rst_o));
endmodule

// File: tb/reset_sequencer_tb_top.sv
module reset_sequencer_tb_top;
  localparam int CLK_P = 10;
  localparam int PWRT = 8;
  localparam int OST  = 12;

  logic clk = 1'b0;
  logic por_ok = 1'b0, mclr_n = 1'b0, xtal = 1'b0;
  logic slow_tick = 1'b0, osc_tick = 1'b0, wdt = 1'b0;
  logic sleeping = 1'b0, wake_evt = 1'b0, clrwdt = 1'b0;
  logic chip_rst, wake_done, to_b, pd_b;

  always #(CLK_P/2) clk = ~clk;

  reset_sequencer #(.PWRT_TICKS(PWRT), .OST_CYCLES(OST)) dut_i (
    .clk_i(clk), .por_ok_i(por_ok), .mclr_ni(mclr_n), .osc_xtal_i(xtal),
    .slow_tick_i(slow_tick), .osc_tick_i(osc_tick), .wdt_timeout_i(wdt),
    .sleeping_i(sleeping), .wake_evt_i(wake_evt), .clrwdt_i(clrwdt),
    .chip_rst_o(chip_rst), .wake_done_o(wake_done), .to_o(to_b), .pd_o(pd_b)
  );

  typedef struct {
    int          due;
    logic [3:0]  val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every due entry a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due == cyc) begin
          n_cmp++;
          if ({chip_rst, to_b, pd_b, wake_done} !== q[i].val) begin
            n_bad++;
            $display("FAIL %s: rst/to/pd/wd=%b expected %b (cycle %0d)",
                     q[i].tag, {chip_rst, to_b, pd_b, wake_done}, q[i].val, cyc);
          end
          q.delete(i);
        end
      end
    end
  end

  task automatic expect_in(input int k, input logic r, input logic t,
                           input logic p, input logic w, input string tag);
    exp_t e;
    e.due = cyc + k;
    e.val = {r, t, p, w};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_slow(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic pulse_osc(input int n);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: held in power-on state
    expect_in(1, 1, 1, 1, 0, "R1");
    idle(3);
    por_ok = 1'b1;
    // R4: ticks while master clear is low are ignored
    pulse_slow(PWRT + 2);
    pulse_osc(3);
    expect_in(1, 1, 1, 1, 0, "R4 ignored while mclr low");
    idle(2);
    mclr_n = 1'b1;
    pulse_slow(PWRT - 1);
    pulse_osc(OST);  // R2: oscillator ticks irrelevant in RC mode
    expect_in(1, 1, 1, 1, 0, "R2 one tick short");
    idle(2);
    mclr_n = 1'b0;
    idle(2);
    mclr_n = 1'b1;
    pulse_slow(PWRT - 1);
    expect_in(1, 1, 1, 1, 0, "R4 restart after mclr pulse");
    idle(2);
    pulse_slow(1);
    expect_in(1, 0, 1, 1, 0, "R2 released");
    idle(4);

    // R5: master clear while awake, no delay on release
    mclr_n = 1'b0;
    expect_in(1, 1, 1, 1, 0, "R5 awake mclr");
    idle(3);
    mclr_n = 1'b1;
    expect_in(1, 0, 1, 1, 0, "R5 immediate release");
    idle(3);
    // R5: master clear during sleep gives 10
    sleeping = 1'b1;
    mclr_n = 1'b0;
    expect_in(1, 1, 1, 0, 0, "R5 sleeping mclr");
    idle(2);
    mclr_n = 1'b1;
    sleeping = 1'b0;
    expect_in(1, 0, 1, 0, 0, "R5 status kept 10");
    idle(3);

    // R10: clear-watchdog sets 11
    clrwdt = 1'b1;
    expect_in(1, 0, 1, 1, 0, "R10 clrwdt");
    idle(1);
    clrwdt = 1'b0;
    idle(2);

    // R6: awake watchdog expiry
    wdt = 1'b1;
    expect_in(1, 1, 0, 1, 0, "R6 wdt reset");
    expect_in(2, 0, 0, 1, 0, "R6 one cycle only");
    idle(1);
    wdt = 1'b0;
    idle(3);

    // R11: wake request while awake has no effect
    wake_evt = 1'b1;
    expect_in(1, 0, 0, 1, 0, "R11 ignored");
    expect_in(2, 0, 0, 1, 0, "R11 no wake pulse");
    idle(1);
    wake_evt = 1'b0;
    idle(3);

    // R8: interrupt wake-up, RC mode
    sleeping = 1'b1;
    wake_evt = 1'b1;
    expect_in(1, 0, 1, 0, 0, "R8 wake status");
    expect_in(2, 0, 1, 0, 1, "R8 wake pulse");
    expect_in(3, 0, 1, 0, 0, "R8 pulse ends");
    idle(1);
    wake_evt = 1'b0;
    idle(3);
    sleeping = 1'b0;
    idle(2);

    // R7: watchdog during sleep
    sleeping = 1'b1;
    wdt = 1'b1;
    expect_in(1, 0, 0, 0, 0, "R7 wdt in sleep");
    expect_in(2, 0, 0, 0, 1, "R7 resume pulse");
    expect_in(3, 0, 0, 0, 0, "R7 pulse ends");
    idle(1);
    wdt = 1'b0;
    idle(3);
    sleeping = 1'b0;
    idle(2);

    // R9: crystal wake-up waits for the start-up count
    xtal = 1'b1;
    sleeping = 1'b1;
    wake_evt = 1'b1;
    expect_in(1, 0, 1, 0, 0, "R9 wake status");
    idle(1);
    wake_evt = 1'b0;
    pulse_osc(OST - 1);
    expect_in(1, 0, 1, 0, 0, "R9 waiting for count");
    idle(2);
    pulse_osc(1);
    expect_in(1, 0, 1, 0, 1, "R9 wake pulse");
    expect_in(2, 0, 1, 0, 0, "R9 pulse ends");
    idle(3);
    sleeping = 1'b0;
    idle(2);

    // R1: power-on asserts asynchronously
    por_ok = 1'b0;
    expect_in(1, 1, 1, 1, 0, "R1 power drop");
    idle(3);
    // R3: crystal power-up, oscillator count finishes later
    por_ok = 1'b1;
    pulse_slow(PWRT);
    expect_in(1, 1, 1, 1, 0, "R3 waiting for osc count");
    idle(2);
    pulse_osc(OST - 1);
    expect_in(1, 1, 1, 1, 0, "R3 osc one short");
    idle(2);
    pulse_osc(1);
    expect_in(1, 0, 1, 1, 0, "R3 released");
    idle(5);

    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d entries left, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule